// File: doc/BRIEF.md
# Fault-Tolerant Write-Through Cache Controller

This block is a single-level, direct-mapped cache controller with one data word per line. It sits between a processor and a lower-level memory that is taken to be free of errors. A per-line fault map marks storage words known to be defective. Any access to a marked line is forced down the normal miss path and served by the lower level, so a defective cell costs extra latency and never returns wrong data. Writes always go through to the lower level.

The processor side has a request channel with a valid/ready handshake. A request is taken on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` is high only while the controller is idle, so the processor holds its request until then. The response is a one-cycle pulse on `cpu_rsp_valid`. It carries no back-pressure, and the processor must take it in that cycle. The lower-level side raises `mem_req` (with `mem_we` for writes) and holds it with a stable address until `mem_rdy` is seen. The fault map is loaded through a plain configuration port, normally before traffic starts.

Address split: the line index is `addr[IDX_W-1:0]` and the tag is `addr[ADDR_W-1:IDX_W]`, with `IDX_W = log2(LINES)`.

Top module: `wtc_ctrl`

## Requirements
- R1: After reset every line is invalid. Reset also leaves `cpu_req_ready` high, `cpu_rsp_valid` low and `mem_req` low, so the first read of any address misses.
- R2: A read is a hit when the indexed line is valid, its tag matches and its fault bit is clear. The data then appears with `cpu_rsp_valid` in the cycle right after the request is taken, and no lower-level request is made.
- R3: When the fault bit of the addressed line is set, the access is handled as a miss even if the line is valid and its tag matches.
- R4: On a read miss, `mem_req` rises with `mem_we` low and `mem_addr` equal to the request address. It stays high, with a stable address, through a wait state until `mem_rdy`. The returned word is delivered with `cpu_rsp_valid` in the cycle after the `mem_rdy` cycle.
- R5: A read miss to a line whose fault bit is clear refills that line, so a repeated read of the same address hits.
- R6: Every write issues exactly one lower-level transfer with `mem_we` high and the request address and data. The write is acknowledged with `cpu_rsp_valid` in the cycle after the `mem_rdy` cycle.
- R7: A write hit updates the cached word. With `WRITE_ALLOC=1` (default), a write miss allocates the line with the new tag and data. Later reads of that address then hit and return the written value.
- R8: A refill or write to a line whose fault bit is set leaves that line's valid bit, tag and data unchanged. The read data still goes to the processor, and the write data still goes to the lower level.
- R9: `cpu_rsp_valid` pulses for exactly one cycle per completed access. `cpu_req_ready` is low from the cycle a request is taken until the controller is idle again.
- R10: A cycle with `cfg_load` high loads `cfg_map` into the fault map, where bit i marks line i as faulty. The new map applies to every access that starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the fault map |
| cfg_map | input | LINES | Fault map value, one bit per line |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can take a request (idle) |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read data, valid with cpu_rsp_valid on reads |
| mem_req | output | 1 | Lower-level request, held until mem_rdy |
| mem_we | output | 1 | Lower-level write select |
| mem_addr | output | ADDR_W | Lower-level address |
| mem_wdata | output | DATA_W | Lower-level write data |
| mem_rdy | input | 1 | Lower level has completed the transfer |
| mem_rdata | input | DATA_W | Lower-level read data, valid with mem_rdy |

## Verification
A read hit must answer in the first cycle after acceptance. Every miss and every write must answer exactly one cycle after the cycle in which `mem_rdy` was high. The bench samples at the falling edge and counts cycles from the acceptance edge. It records the cycle of `mem_rdy` and compares the response cycle against that number, not against a fixed window. The lower-level model applies a random 0 to 3 cycle delay to exercise the wait state. On each access, a bench model of valid, tag, data and fault bits predicts whether a lower-level transfer should occur and which data is due. In the cycle after each response, the bench also checks that `cpu_rsp_valid` has dropped.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOOKUP  = 3'd1,
    ST_RD_MISS = 3'd2,
    ST_RD_WAIT = 3'd3,
    ST_RD_DATA = 3'd4,
    ST_WR_SEND = 3'd5,
    ST_WR_WAIT = 3'd6,
    ST_WR_DATA = 3'd7
  } wtc_state_e;

endpackage

// File: rtl/wtc_fault_map.sv
module wtc_fault_map #(
  parameter int LINES = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [LINES-1:0] cfg_map,
  input  logic [IDX_W-1:0] idx,
  output logic             faulty
);

  logic [LINES-1:0] map_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        map_q <= '0;
    else if (cfg_load) map_q <= cfg_map;
  end

  assign faulty = map_q[idx];

endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int LINES  = 16,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_match,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic              valid_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_q[g] <= 1'b0;
      else if (sel) valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[g]  <= wr_tag;
        data_q[g] <= wr_data;
      end
    end
  end

  assign rd_match = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_data  = data_q[rd_idx];

endmodule

// File: rtl/wtc_ctrl_fsm.sv
module wtc_ctrl_fsm
  import wtc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              lk_match,
  input  logic              lk_fault,
  input  logic [DATA_W-1:0] lk_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rdy,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] req_addr,
  output logic              st_wr_en,
  output logic [DATA_W-1:0] st_wr_data,
  output wtc_state_e        state
);

  wtc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, fill_q;
  logic              we_q, hit_q;
  logic              usable;
  logic              wr_store_ok;

  assign usable = lk_match && !lk_fault;

  // Variant: allocate on write miss, or update on write hit only
  if (WRITE_ALLOC) begin : g_alloc
    assign wr_store_ok = 1'b1;
  end else begin : g_no_alloc
    assign wr_store_ok = hit_q;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (cpu_req_valid) state_d = ST_LOOKUP;
      ST_LOOKUP:  if (we_q)          state_d = ST_WR_SEND;
                  else if (usable)   state_d = ST_IDLE;
                  else               state_d = ST_RD_MISS;
      ST_RD_MISS: state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rdy)       state_d = ST_RD_DATA;
      ST_RD_DATA: state_d = ST_IDLE;
      ST_WR_SEND: state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (mem_rdy)       state_d = ST_WR_DATA;
      ST_WR_DATA: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      fill_q  <= '0;
      we_q    <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_req_valid) begin
        addr_q  <= cpu_req_addr;
        wdata_q <= cpu_req_wdata;
        we_q    <= cpu_req_we;
      end
      if (state_q == ST_LOOKUP) hit_q <= usable;
      if (state_q == ST_RD_WAIT && mem_rdy) fill_q <= mem_rdata;
    end
  end

  assign state         = state_q;
  assign req_addr      = addr_q;
  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_LOOKUP && !we_q && usable) ||
                         (state_q == ST_RD_DATA) || (state_q == ST_WR_DATA);
  assign cpu_rsp_rdata = (state_q == ST_LOOKUP) ? lk_data : fill_q;

  assign mem_req   = (state_q == ST_RD_MISS) || (state_q == ST_RD_WAIT) ||
                     (state_q == ST_WR_SEND) || (state_q == ST_WR_WAIT);
  assign mem_we    = (state_q == ST_WR_SEND) || (state_q == ST_WR_WAIT);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  assign st_wr_en   = !lk_fault &&
                      ((state_q == ST_RD_DATA) ||
                       (state_q == ST_WR_DATA && wr_store_ok));
  assign st_wr_data = (state_q == ST_RD_DATA) ? fill_q : wdata_q;

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  // R4
  rd_wait_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_MISS) |=> (state_q == ST_RD_WAIT));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6
  wr_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOKUP && we_q) |=> (mem_req && mem_we));

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int LINES       = 16,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [LINES-1:0]  cfg_map,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rdy,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] req_addr;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              lk_match, lk_fault;
  logic [DATA_W-1:0] lk_data;
  logic              st_wr_en;
  logic [DATA_W-1:0] st_wr_data;
  wtc_state_e        state;

  assign req_idx = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];

  wtc_fault_map #(.LINES(LINES), .IDX_W(IDX_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_map  (cfg_map),
    .idx      (req_idx),
    .faulty   (lk_fault)
  );

  wtc_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_tag   (req_tag),
    .rd_match (lk_match),
    .rd_data  (lk_data),
    .wr_en    (st_wr_en),
    .wr_idx   (req_idx),
    .wr_tag   (req_tag),
    .wr_data  (st_wr_data)
  );

  wtc_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_ALLOC(WRITE_ALLOC)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_we    (cpu_req_we),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_rdata (cpu_rsp_rdata),
    .lk_match      (lk_match),
    .lk_fault      (lk_fault),
    .lk_data       (lk_data),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdy       (mem_rdy),
    .mem_rdata     (mem_rdata),
    .req_addr      (req_addr),
    .st_wr_en      (st_wr_en),
    .st_wr_data    (st_wr_data),
    .state         (state)
  );

  // R3
  fault_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOKUP && lk_fault) |-> !cpu_rsp_valid);

  // R8
  fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |-> !lk_fault);

  // R2
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOKUP && cpu_rsp_valid) |=> !mem_req);

endmodule

// File: tb/wtc_ctrl_bench.sv
module wtc_ctrl_bench;

  localparam int LINES  = 16;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_load = 1'b0;
  logic [LINES-1:0]  cfg_map = '0;
  logic              cpu_req_valid = 1'b0;
  logic              cpu_req_ready;
  logic              cpu_req_we = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic              cpu_rsp_valid;
  logic [DATA_W-1:0] cpu_rsp_rdata;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_rdy = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wtc_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_ALLOC(1'b1)) u_wtc_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_map(cfg_map),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Reference model
  logic [DATA_W-1:0] ref_mem   [256];
  logic [DATA_W-1:0] lower_mem [256];
  bit                rv [LINES];
  logic [3:0]        rt [LINES];
  logic [DATA_W-1:0] rd [LINES];
  logic [LINES-1:0]  fm = '0;

  // Lower-level observation
  int                mem_txn = 0;
  logic              last_we;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_wdata;

  function automatic logic [DATA_W-1:0] init_word(input int a);
    return DATA_W'(a * 40503) ^ 16'h5A5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Lower-level memory model, random 0..3 cycle wait
  initial begin
    int busy = 0;
    int wt = 0;
    forever begin
      @(posedge clk);
      #1;
      if (mem_rdy) mem_rdy = 1'b0;
      else if (busy != 0) begin
        if (wt == 0) begin
          if (mem_we) lower_mem[mem_addr] = mem_wdata;
          else        mem_rdata = lower_mem[mem_addr];
          last_we = mem_we; last_addr = mem_addr; last_wdata = mem_wdata;
          mem_txn++;
          mem_rdy = 1'b1;
          busy = 0;
        end else wt--;
      end else if (mem_req) begin
        busy = 1;
        wt = int'($urandom % 4);
      end
    end
  end

  task automatic load_map(input logic [LINES-1:0] m);
    @(negedge clk);
    cfg_load = 1'b1; cfg_map = m;
    @(negedge clk);
    cfg_load = 1'b0;
    fm = m;
  endtask

  task automatic access(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd);
    logic [3:0] idx, tg;
    bit         exp_hit, flt;
    logic [DATA_W-1:0] exp_d;
    int txn0, cyc, rdy_cyc;
    idx = a[3:0]; tg = a[7:4];
    flt = fm[idx];
    exp_hit = rv[idx] && (rt[idx] == tg) && !flt;
    exp_d = exp_hit ? rd[idx] : ref_mem[a];
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R9 ready in idle", 32'(cpu_req_ready), 1);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    txn0 = mem_txn;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    cyc = 1; rdy_cyc = -10;
    while (!cpu_rsp_valid && cyc < 50) begin
      if (cpu_req_ready) check(1'b0, "R9 ready low while busy", 1, 0);
      if (mem_rdy) rdy_cyc = cyc;
      @(negedge clk);
      cyc++;
    end
    check(cpu_rsp_valid == 1'b1, "R9 response arrives", 32'(cpu_rsp_valid), 1);
    if (!we && exp_hit) begin
      check(cyc == 1, "R2 hit latency", 32'(cyc), 1);
      check(mem_txn == txn0, "R2 no lower access on hit", 32'(mem_txn - txn0), 0);
      check(cpu_rsp_rdata == exp_d, "R2 hit data", 32'(cpu_rsp_rdata), 32'(exp_d));
    end else if (!we) begin
      check(mem_txn == txn0 + 1, flt ? "R3 faulty line read misses" : "R4 one refill",
            32'(mem_txn - txn0), 1);
      check(last_we == 1'b0 && last_addr == a, "R4 refill address", 32'(last_addr), 32'(a));
      check(cyc == rdy_cyc + 1, "R4 response after ready", 32'(cyc), 32'(rdy_cyc + 1));
      check(cpu_rsp_rdata == exp_d, flt ? "R8 faulty read data" : "R4 miss data",
            32'(cpu_rsp_rdata), 32'(exp_d));
    end else begin
      check(mem_txn == txn0 + 1, "R6 one write transfer", 32'(mem_txn - txn0), 1);
      check(last_we && last_addr == a && last_wdata == wd, "R6 write addr/data",
            32'(last_wdata), 32'(wd));
      check(cyc == rdy_cyc + 1, "R6 ack after ready", 32'(cyc), 32'(rdy_cyc + 1));
    end
    @(negedge clk);
    check(cpu_rsp_valid == 1'b0, "R9 single-cycle response", 32'(cpu_rsp_valid), 0);
    // Update the model
    if (!we) begin
      if (!exp_hit && !flt) begin rv[idx] = 1'b1; rt[idx] = tg; rd[idx] = ref_mem[a]; end
    end else begin
      ref_mem[a] = wd;
      if (!flt) begin
        if (exp_hit) rd[idx] = wd;
        else begin rv[idx] = 1'b1; rt[idx] = tg; rd[idx] = wd; end
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      ref_mem[i] = init_word(i);
      lower_mem[i] = init_word(i);
    end
    for (int i = 0; i < LINES; i++) begin rv[i] = 1'b0; rt[i] = '0; rd[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cpu_req_ready == 1'b1, "R1 ready after reset", 32'(cpu_req_ready), 1);
    check(cpu_rsp_valid == 1'b0, "R1 no response after reset", 32'(cpu_rsp_valid), 0);
    check(mem_req == 1'b0, "R1 no lower request after reset", 32'(mem_req), 0);

    load_map('0);
    access(1'b0, 8'h13, '0);          // R1 cold miss
    access(1'b0, 8'h13, '0);          // R5 refilled line now hits
    access(1'b0, 8'h23, '0);          // conflicting tag
    access(1'b0, 8'h13, '0);
    access(1'b1, 8'h33, 16'hBEEF);    // R7 write miss allocates
    access(1'b0, 8'h33, '0);          // R7 hit returns written value
    access(1'b1, 8'h33, 16'hCAFE);    // R7 write hit
    access(1'b0, 8'h33, '0);

    load_map(16'h0008);               // R10 mark line 3 faulty
    access(1'b0, 8'h33, '0);          // R3 valid+match but faulty: miss
    access(1'b1, 8'h33, 16'h1234);    // R8 goes through, line untouched
    access(1'b0, 8'h43, '0);          // R8 refill skipped
    load_map('0);
    access(1'b0, 8'h33, '0);          // R8 stale CAFE still cached: hit
    access(1'b0, 8'h43, '0);          // R8 line kept old tag: miss

    load_map(16'h0491);               // R10 scattered faults
    for (int k = 0; k < 400; k++) begin
      access(($urandom % 3) == 0, ADDR_W'($urandom % 64), DATA_W'($urandom));
    end
    for (int i = 0; i < 64; i++) begin
      check(lower_mem[i] == ref_mem[i], "R6 lower memory content",
            32'(lower_mem[i]), 32'(ref_mem[i]));
    end
    finish_run();
  end

endmodule